// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block lets a local host reach a 32-bit register space that sits behind a 16-bit management bus. The host issues one 32-bit read or write with a byte address. The bridge turns it into three management transactions in a fixed sequence. The first is always a write to a fixed page-select register. The other two move the two 16-bit halves of the data word, each to a PHY and register address pair derived from the word address. For a read, the two returned halves are joined back into one 32-bit value.

The downstream side is a request/acknowledge port. It drives a clause-22 style management master, which does the serial signalling. A mode input lets writes send the upper half first, with one address left in the normal order. The bridge serves one host request at a time. It raises busy while a sequence runs, and it pulses done once the last transaction has been acknowledged.

Top module: `paged_reg_bridge`

## Requirements
- R1: Bits [1:0] of `req_addr` have no effect. The word address is `req_addr[31:2]`.
- R2: Every access begins with a management write to PHY 0x1F, register 0x10. Its data is the word address shifted right by 7 and truncated to 16 bits, which equals `req_addr[24:9]`.
- R3: Both data-phase transactions use PHY address 0x10 OR word address bits [6:4], so that address is always in 0x10..0x17.
- R4: The lower half uses register `{word[3:0],0}` and carries write-data bits [15:0]. The upper half uses register `{word[3:0],1}` and carries bits [31:16].
- R5: A read always fetches the lower half and then the upper half, whatever the mode. `rsp_rdata` then equals {upper data, lower data}.
- R6: With `hi_first_mode`=0 (its value is sampled when the request is accepted), a write sends the lower half and then the upper half.
- R7: With `hi_first_mode`=1, a write sends the upper half first. The exception is any byte address in word 0x26 (byte 0x98..0x9B), which keeps the lower-then-upper order.
- R8: The page write is issued again on every access, even when the page value has not changed.
- R9: `busy` is high from the cycle after acceptance until the last acknowledge. A `req_valid` seen while `busy` is high is ignored and causes no transaction.
- R10: `rsp_done` is high for exactly one cycle, in the cycle after the final `mb_ack`, and never while `busy` is high.
- R11: `mb_req` and all its fields hold steady until `mb_ack`. The next transaction is not presented before that acknowledge.
- R12: After reset, `busy`, `rsp_done` and `mb_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_first_mode | input | 1 | Selects the upper-half-first write order, sampled at acceptance |
| req_valid | input | 1 | Host access strobe, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write data |
| rsp_rdata | output | 32 | Reassembled read data, valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A sequence is in progress |
| mb_req | output | 1 | Management transaction request |
| mb_write | output | 1 | 1 = management write, 0 = read |
| mb_phy | output | 5 | Management PHY address |
| mb_reg | output | 5 | Management register address |
| mb_wdata | output | 16 | Management write data |
| mb_ack | input | 1 | Transaction acknowledge, one cycle |
| mb_rdata | input | 16 | Read data, valid with mb_ack |

## Verification
The bench targets several corner cases and the failure each one would show:
- The word holding byte 0x98 in upper-first mode, where a design that ignores the exception would send the upper half first.
- A read made in that same mode, where a design that applies the swap to reads would return its halves exchanged.
- The address 0xFFFFFFFC, which exposes a page or PHY field that is too wide or shifted by the wrong amount.
- Two addresses that differ only in their low two bits, which must produce identical transactions.
- A host strobe given mid-sequence, which a design without request locking would turn into extra transactions.
- Acknowledges that come late, which catch a design that advances before the acknowledge or sends its done pulse early.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int MB_AW = 5;
  localparam int MB_DW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE
  } prb_state_e;

  typedef struct packed {
    logic             wr;
    logic [MB_AW-1:0] phy;
    logic [MB_AW-1:0] regad;
    logic [MB_DW-1:0] data;
  } prb_xfer_t;
endpackage

// File: rtl/prb_addr_map.sv
module prb_addr_map
  import prb_pkg::*;
#(
  parameter int               HOST_AW         = 32,
  parameter int               PAGE_SHIFT      = 7,
  parameter logic [MB_AW-1:0] PAGE_PHY        = 5'h1F,
  parameter logic [MB_AW-1:0] PAGE_REG        = 5'h10,
  parameter logic [MB_AW-1:0] DATA_PHY_BASE   = 5'h10,
  parameter logic [HOST_AW-1:0] KEEP_ORDER_ADDR = 'h98
) (
  input  logic [HOST_AW-1:0] addr,
  input  logic [2*MB_DW-1:0] wdata,
  input  logic               write,
  input  logic               hi_first,
  output prb_xfer_t          page_x,
  output prb_xfer_t          first_x,
  output prb_xfer_t          second_x
);
  localparam int WAW       = HOST_AW - 2;
  localparam int REG_IDX_W = MB_AW - 1;
  localparam int PHY_SEL_W = 3;

  logic [WAW-1:0]   word;
  logic [WAW-1:0]   page_full;
  logic [MB_AW-1:0] data_phy;
  logic             swap;
  prb_xfer_t        half_x [2];

  assign word      = addr[HOST_AW-1:2];
  assign page_full = word >> PAGE_SHIFT;
  assign data_phy  = DATA_PHY_BASE | MB_AW'(word[REG_IDX_W +: PHY_SEL_W]);

  assign page_x = '{wr: 1'b1, phy: PAGE_PHY, regad: PAGE_REG,
                    data: page_full[MB_DW-1:0]};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_x[h] = '{wr: write, phy: data_phy,
                         regad: {word[REG_IDX_W-1:0], (h == 1)},
                         data: wdata[h*MB_DW +: MB_DW]};
  end

  assign swap     = write && hi_first && (word != KEEP_ORDER_ADDR[HOST_AW-1:2]);
  assign first_x  = swap ? half_x[1] : half_x[0];
  assign second_x = swap ? half_x[0] : half_x[1];
endmodule

// File: rtl/prb_seq.sv
module prb_seq
  import prb_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       start,
  input  logic       ack,
  output prb_state_e state,
  output logic       accept,
  output logic       busy,
  output logic       done
);
  prb_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (start) state_d = ST_PAGE;
      ST_PAGE:   if (ack)   state_d = ST_FIRST;
      ST_FIRST:  if (ack)   state_d = ST_SECOND;
      ST_SECOND: if (ack)   state_d = ST_DONE;
      ST_DONE:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= ST_IDLE;
    else         state <= state_d;
  end

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state == ST_PAGE) || (state == ST_FIRST) || (state == ST_SECOND);
  assign done   = (state == ST_DONE);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !done);
  p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> $past(ack));
  p_busy_excl_done_r9: assert property (@(posedge clk) disable iff (!arst_n)
    busy |-> !done);
  p_wait_ack_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && !ack) |=> $stable(state));
endmodule

// File: rtl/prb_rd_gather.sv
module prb_rd_gather
  import prb_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               cap_lo,
  input  logic               cap_hi,
  input  logic [MB_DW-1:0]   half_in,
  output logic [2*MB_DW-1:0] word_out
);
  logic [MB_DW-1:0] lo_q;
  logic [MB_DW-1:0] hi_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     lo_q <= '0;
    else if (cap_lo) lo_q <= half_in;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     hi_q <= '0;
    else if (cap_hi) hi_q <= half_in;
  end

  assign word_out = {hi_q, lo_q};

  p_one_half_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !(cap_lo && cap_hi));
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import prb_pkg::*;
#(
  parameter int                 HOST_AW         = 32,
  parameter int                 PAGE_SHIFT      = 7,
  parameter logic [MB_AW-1:0]   PAGE_PHY        = 5'h1F,
  parameter logic [MB_AW-1:0]   PAGE_REG        = 5'h10,
  parameter logic [MB_AW-1:0]   DATA_PHY_BASE   = 5'h10,
  parameter logic [HOST_AW-1:0] KEEP_ORDER_ADDR = 'h98
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_first_mode,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [2*MB_DW-1:0] req_wdata,
  output logic [2*MB_DW-1:0] rsp_rdata,
  output logic               rsp_done,
  output logic               busy,
  output logic               mb_req,
  output logic               mb_write,
  output logic [MB_AW-1:0]   mb_phy,
  output logic [MB_AW-1:0]   mb_reg,
  output logic [MB_DW-1:0]   mb_wdata,
  input  logic               mb_ack,
  input  logic [MB_DW-1:0]   mb_rdata
);
  localparam int HDW = 2 * MB_DW;

  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  prb_state_e state;
  logic       accept;

  prb_seq u_seq (
    .clk    (clk),
    .arst_n (arst_n),
    .start  (req_valid),
    .ack    (mb_ack),
    .state  (state),
    .accept (accept),
    .busy   (busy),
    .done   (rsp_done)
  );

  logic [HOST_AW-1:0] addr_q;
  logic [HDW-1:0]     wdata_q;
  logic               write_q;
  logic               mode_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      mode_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      mode_q  <= hi_first_mode;
    end
  end

  prb_xfer_t page_x, first_x, second_x, cur_x;

  prb_addr_map #(
    .HOST_AW         (HOST_AW),
    .PAGE_SHIFT      (PAGE_SHIFT),
    .PAGE_PHY        (PAGE_PHY),
    .PAGE_REG        (PAGE_REG),
    .DATA_PHY_BASE   (DATA_PHY_BASE),
    .KEEP_ORDER_ADDR (KEEP_ORDER_ADDR)
  ) u_map (
    .addr     (addr_q),
    .wdata    (wdata_q),
    .write    (write_q),
    .hi_first (mode_q),
    .page_x   (page_x),
    .first_x  (first_x),
    .second_x (second_x)
  );

  always_comb begin
    cur_x = '0;
    unique case (state)
      ST_PAGE:   cur_x = page_x;
      ST_FIRST:  cur_x = first_x;
      ST_SECOND: cur_x = second_x;
      default:   cur_x = '0;
    endcase
  end

  assign mb_req   = busy;
  assign mb_write = cur_x.wr;
  assign mb_phy   = cur_x.phy;
  assign mb_reg   = cur_x.regad;
  assign mb_wdata = cur_x.data;

  logic cap_lo, cap_hi;
  assign cap_lo = mb_ack && !write_q && (state == ST_FIRST);
  assign cap_hi = mb_ack && !write_q && (state == ST_SECOND);

  prb_rd_gather u_gather (
    .clk      (clk),
    .arst_n   (arst_n),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .half_in  (mb_rdata),
    .word_out (rsp_rdata)
  );

  p_hold_fields_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (mb_req && !mb_ack) |=> (mb_req && $stable({mb_write, mb_phy, mb_reg, mb_wdata})));
  p_page_first_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(busy) |-> (mb_req && mb_write && mb_phy == PAGE_PHY && mb_reg == PAGE_REG));
  p_phy_range_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (mb_req && mb_phy != PAGE_PHY) |-> ((mb_phy & ~5'h07) == DATA_PHY_BASE));
  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!arst_n)
    !busy |-> !mb_req);
endmodule

// File: tb/paged_reg_bridge_test.sv
module paged_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hi_first_mode, req_valid, req_write;
  logic [31:0] req_addr, req_wdata, rsp_rdata;
  logic        rsp_done, busy, mb_req, mb_write, mb_ack;
  logic [4:0]  mb_phy, mb_reg;
  logic [15:0] mb_wdata, mb_rdata;

  always #2 clk = ~clk;

  paged_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .hi_first_mode(hi_first_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .busy(busy), .mb_req(mb_req), .mb_write(mb_write), .mb_phy(mb_phy),
    .mb_reg(mb_reg), .mb_wdata(mb_wdata), .mb_ack(mb_ack), .mb_rdata(mb_rdata)
  );

  typedef struct packed {
    bit          wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
  } exp_t;

  typedef struct packed {
    bit          wr;
    logic [31:0] rd;
  } done_t;

  exp_t  exp_q[$];
  string tag_q[$];
  done_t done_q[$];
  string dtag_q[$];
  int    checks = 0;
  int    failures = 0;
  int    done_seen = 0;
  int    lat = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2B} ^ 16'h5A5A;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Driver: pushes the expected transaction stream, then strobes the request.
  task automatic do_access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                           input bit mode, input string tag, input bit poke);
    logic [29:0] w;
    logic [4:0]  phy;
    exp_t        lo, hi;
    bit          hi_first;
    int          target;
    w   = a[31:2];
    phy = 5'h10 | {2'b00, w[6:4]};
    lo  = '{wr: wr, phy: phy, rg: {w[3:0], 1'b0}, data: d[15:0]};
    hi  = '{wr: wr, phy: phy, rg: {w[3:0], 1'b1}, data: d[31:16]};
    hi_first = wr && mode && (w != 30'h26);
    exp_q.push_back('{wr: 1'b1, phy: 5'h1F, rg: 5'h10, data: a[24:9]});
    tag_q.push_back({tag, " R2 R8"});
    exp_q.push_back(hi_first ? hi : lo);
    tag_q.push_back({tag, " R3 R4"});
    exp_q.push_back(hi_first ? lo : hi);
    tag_q.push_back({tag, " R3 R4"});
    done_q.push_back('{wr: wr, rd: {rd_val(phy, hi.rg), rd_val(phy, lo.rg)}});
    dtag_q.push_back(tag);
    target = done_seen + 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; hi_first_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk(busy == 1'b1, "R9", "busy during sequence", {31'b0, busy}, 32'd1);
      req_valid = 1'b1; req_write = ~wr; req_addr = a ^ 32'h0000_4440;
      hi_first_mode = ~mode;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_seen < target) @(negedge clk);
    @(negedge clk);
  endtask

  // Responder / monitor of the management port.
  initial begin
    exp_t  e;
    string t;
    mb_ack = 1'b0;
    mb_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mb_req && !mb_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected transaction",
              {5'b0, mb_write, mb_phy, mb_reg, mb_wdata}, 32'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(mb_write == e.wr && mb_phy == e.phy && mb_reg == e.rg &&
              (!e.wr || mb_wdata == e.data), t, "transaction",
              {5'b0, mb_write, mb_phy, mb_reg, mb_wdata},
              {5'b0, e.wr, e.phy, e.rg, e.data});
        end
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 4;
        mb_ack = 1'b1;
        mb_rdata = rd_val(mb_phy, mb_reg);
        @(negedge clk);
        mb_ack = 1'b0;
      end
    end
  end

  // Completion monitor: pops expected results as done pulses appear.
  initial begin
    done_t d;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_done) begin
        done_seen++;
        chk(exp_q.size() == 0, "R10", "done after final ack", exp_q.size(), 32'd0);
        chk(busy == 1'b0, "R10", "done while busy", {31'b0, busy}, 32'd0);
        if (done_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
        end else begin
          d = done_q.pop_front();
          t = dtag_q.pop_front();
          if (!d.wr) chk(rsp_rdata == d.rd, {t, " R5"}, "read data", rsp_rdata, d.rd);
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R10", "done width", {31'b0, rsp_done}, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hi_first_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    chk(busy == 0 && rsp_done == 0 && mb_req == 0, "R12", "reset outputs",
        {29'b0, busy, rsp_done, mb_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && rsp_done == 0 && mb_req == 0, "R12", "idle after reset",
        {29'b0, busy, rsp_done, mb_req}, 32'd0);

    do_access(1'b0, 32'h0000_1234, 32'h0, 1'b0, "R5", 1'b0);
    do_access(1'b0, 32'h0000_1237, 32'h0, 1'b0, "R1", 1'b0);
    do_access(1'b1, 32'h0004_0FFC, 32'hCAFE_BABE, 1'b0, "R6", 1'b0);
    do_access(1'b1, 32'h0000_0040, 32'h1111_2222, 1'b1, "R7", 1'b0);
    do_access(1'b1, 32'h0000_0098, 32'h3333_4444, 1'b1, "R7", 1'b0);
    do_access(1'b1, 32'h0000_009B, 32'h5555_6666, 1'b1, "R7", 1'b0);
    do_access(1'b1, 32'h0000_009C, 32'h7777_8888, 1'b1, "R7", 1'b0);
    do_access(1'b0, 32'h0000_0098, 32'h0, 1'b1, "R5", 1'b0);
    do_access(1'b0, 32'h0000_00A0, 32'h0, 1'b1, "R5", 1'b0);
    do_access(1'b1, 32'h0000_0104, 32'hA5A5_5A5A, 1'b0, "R8", 1'b0);
    do_access(1'b1, 32'h0000_0108, 32'h0F0F_F0F0, 1'b0, "R8", 1'b0);
    do_access(1'b0, 32'hFFFF_FFFC, 32'h0, 1'b0, "R3", 1'b0);
    do_access(1'b1, 32'hFFFF_FFF0, 32'hDEAD_BEEF, 1'b1, "R3", 1'b0);
    do_access(1'b1, 32'h0012_3450, 32'h0BAD_F00D, 1'b0, "R9", 1'b1);
    do_access(1'b0, 32'h00AB_CDE4, 32'h0, 1'b1, "R9", 1'b1);

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && busy == 0, "R9", "no stray transactions",
        exp_q.size(), 32'd0);
    finish_run();
  end
endmodule